// File: doc/BRIEF.md
# Four-Way Translation Buffer with Replacement Counter

The block caches virtual-to-physical page translations in four ways of 32 sets each. A lookup presents a 32-bit virtual address. After one compare cycle the block answers with a hit and the physical address with the entry's attribute bits, or with a miss, or with a multiple-hit exception when more than one way matches. The set is chosen by bits 16..12 of the address. Optionally these bits are mixed by XOR with the low five bits of the current address space identifier, so that processes sharing page numbers spread over different sets.

A two-bit victim counter names the way that the next refill writes. The counter is loaded by hardware whenever a translation exception occurs, and software may also write it. On a miss the counter takes the lowest-numbered free way at the missed set. If every way there is occupied, the counter advances by one and wraps. For a multiple hit, or a fault reported by neighbouring protection logic, it takes the way involved. The block also holds a fault-address register, a flush command, a translation enable, a single-address-space mode that ignores identifiers, and the current identifier. All of these sit behind a small register port.

The sequencer has two states. It rests in `ST_IDLE`. The transition *accept* moves it to `ST_COMPARE` when a request arrives while ready. The transition *respond* always returns it to `ST_IDLE` one cycle later, and in that same cycle the registered response is loaded.

Top module: `tlb4_top`

## Requirements
- R1: After reset, every register reads 0 and every entry is invalid, so the first enabled lookup misses.
- R2: The set index is VA[16:12]. When control bit 1 (hash) is 1, the index is VA[16:12] XOR identifier[4:0]. Refills index with the same rule, using the refill's own identifier.
- R3: A lookup hits when the selected set holds one valid entry whose page number equals VA[31:12] and whose identifier equals the current one. The identifier comparison is skipped when the entry's shared flag is set or control bit 3 (single space) is 1. A hit returns {PPN, VA[11:0]} and the entry's attribute bits.
- R4: An enabled lookup that matches no way responds with miss, PA 0, attribute 0, and copies its VA into the fault register (address 2).
- R5: On a miss where all four ways of the set are valid, the victim counter (control bits 9:8) increments modulo 4.
- R6: On a miss where at least one way of the set is invalid, the victim counter takes the lowest-numbered invalid way, searching from way 0 up to way 3.
- R7: When two or more ways match, the response is a multiple hit with no hit, PA 0. The counter takes the lowest matching way, and the fault register takes the VA.
- R8: A fault input pulse loads the counter with its way and the fault register with its address. A lookup exception that completes in the same cycle takes precedence over it.
- R9: A refill writes page number, identifier, PPN, shared flag and attributes into the way named by the counter, at the index from R2, and marks that entry valid.
- R10: Writing 1 to control bit 2 invalidates every entry. A refill in the same cycle is discarded. Bit 2 always reads 0.
- R11: Register map: address 0 is control (bit 0 enable, bit 1 hash, bit 2 flush, bit 3 single space, bits 9:8 victim counter). Address 1 holds the current identifier in bits 7:0. Address 2 is the read-only fault address. Unlisted bits and address 3 read 0, and writes to address 2 are ignored.
- R12: With control bit 0 clear, a lookup responds hit with PA equal to VA and attribute 0, and it changes neither the counter nor the fault register.
- R13: A request is accepted only while ready is high. The response valid pulse follows two clock edges after acceptance. Ready is low during the compare cycle. The fault register changes only on exceptions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| lkp_req | input | 1 | Lookup request |
| lkp_ready | output | 1 | High while a request can be accepted |
| lkp_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle pulse: response fields valid |
| rsp_hit | output | 1 | Translation found (or translation disabled) |
| rsp_miss | output | 1 | No matching way |
| rsp_multi | output | 1 | More than one matching way |
| rsp_pa | output | 32 | Physical address |
| rsp_attr | output | 4 | Attribute bits of the hit entry |
| ref_we | input | 1 | Refill write strobe |
| ref_vpn | input | 20 | Refill virtual page number |
| ref_asid | input | 8 | Refill address space identifier |
| ref_ppn | input | 20 | Refill physical page number |
| ref_shared | input | 1 | Refill shared flag |
| ref_attr | input | 4 | Refill attribute bits |
| flt_valid | input | 1 | Non-miss translation fault reported from outside |
| flt_way | input | 2 | Way that caused that fault |
| flt_va | input | 32 | Address of that fault |

## Verification
The hardest condition to reach is a multiple hit. A correct refill path never places one page number twice in a set on its own, because the victim counter moves to a free way after every miss. The stimulus therefore steers the counter by writing control bits 9:8 between two refills of the same page, putting copies in ways 1 and 3. A later lookup must then report the exception and leave the counter at 1. A second awkward case is a fault input arriving in the very cycle a lookup miss resolves. The bench raises the fault input during the compare cycle, so the miss has to win both the counter and the fault register.

// File: rtl/tlb4_pkg.sv
package tlb4_pkg;
    localparam int unsigned VA_W   = 32;
    localparam int unsigned PG_W   = 12;
    localparam int unsigned VPN_W  = VA_W - PG_W;
    localparam int unsigned PA_W   = 32;
    localparam int unsigned PPN_W  = PA_W - PG_W;
    localparam int unsigned ASID_W = 8;
    localparam int unsigned ATTR_W = 4;
    localparam int unsigned N_WAYS = 4;
    localparam int unsigned WAY_W  = $clog2(N_WAYS);
    localparam int unsigned N_SETS = 32;
    localparam int unsigned IDX_W  = $clog2(N_SETS);
    localparam int unsigned REG_W  = 32;

    // register addresses
    localparam logic [1:0] RA_CTRL  = 2'd0;
    localparam logic [1:0] RA_ASID  = 2'd1;
    localparam logic [1:0] RA_FAULT = 2'd2;

    // control bit positions
    localparam int unsigned B_EN     = 0;
    localparam int unsigned B_HASH   = 1;
    localparam int unsigned B_FLUSH  = 2;
    localparam int unsigned B_SINGLE = 3;
    localparam int unsigned B_VICT   = 8;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PPN_W-1:0]  ppn;
        logic              shared;
        logic [ATTR_W-1:0] attr;
    } tlb_entry_t;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_COMPARE = 1'b1
    } lk_state_t;
endpackage

// File: rtl/tlb4_index.sv
module tlb4_index
    import tlb4_pkg::*;
(
    input  logic [VPN_W-1:0]  vpn,
    input  logic [ASID_W-1:0] asid,
    input  logic              hash_en,
    output logic [IDX_W-1:0]  idx
);
    logic unused_hi;
    assign unused_hi = ^{vpn[VPN_W-1:IDX_W], asid[ASID_W-1:IDX_W]};

    always_comb begin
        if (hash_en) idx = vpn[IDX_W-1:0] ^ asid[IDX_W-1:0];
        else         idx = vpn[IDX_W-1:0];
    end
endmodule

// File: rtl/tlb4_way.sv
module tlb4_way
    import tlb4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  tlb_entry_t        wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [VPN_W-1:0]  cmp_vpn,
    input  logic [ASID_W-1:0] cmp_asid,
    input  logic              single_space,
    output logic              rd_valid,
    output logic              rd_match,
    output logic [PPN_W-1:0]  rd_ppn,
    output logic [ATTR_W-1:0] rd_attr
);
    logic [N_SETS-1:0] valid_q;
    tlb_entry_t        ent_q [N_SETS];
    tlb_entry_t        rd_ent;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      valid_q <= '0;
        else if (flush)  valid_q <= '0;
        else if (wr_en)  valid_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en && !flush) ent_q[wr_idx] <= wr_data;
    end

    always_comb begin
        rd_ent   = ent_q[rd_idx];
        rd_valid = valid_q[rd_idx];
        rd_match = rd_valid && (rd_ent.vpn == cmp_vpn) &&
                   (single_space || rd_ent.shared || (rd_ent.asid == cmp_asid));
        rd_ppn   = rd_ent.ppn;
        rd_attr  = rd_ent.attr;
    end
endmodule

// File: rtl/tlb4_victim.sv
module tlb4_victim
    import tlb4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_evt,
    input  logic              multi_evt,
    input  logic [N_WAYS-1:0] valid_vec,
    input  logic [N_WAYS-1:0] hit_vec,
    input  logic              flt_evt,
    input  logic [WAY_W-1:0]  flt_way,
    input  logic              sw_we,
    input  logic [WAY_W-1:0]  sw_way,
    output logic [WAY_W-1:0]  way_q
);
    function automatic logic [WAY_W-1:0] lowest_set(input logic [N_WAYS-1:0] v);
        logic [WAY_W-1:0] r;
        r = '0;
        for (int i = N_WAYS - 1; i >= 0; i--) begin
            if (v[i]) r = WAY_W'(i);
        end
        return r;
    endfunction

    logic [WAY_W-1:0] way_d;

    always_comb begin
        way_d = way_q;
        if (miss_evt) begin
            if (&valid_vec) way_d = way_q + 1'b1;
            else            way_d = lowest_set(~valid_vec);
        end else if (multi_evt) begin
            way_d = lowest_set(hit_vec);
        end else if (flt_evt) begin
            way_d = flt_way;
        end else if (sw_we) begin
            way_d = sw_way;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) way_q <= '0;
        else        way_q <= way_d;
    end
endmodule

// File: rtl/tlb4_top.sv
module tlb4_top
    import tlb4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              lkp_req,
    output logic              lkp_ready,
    input  logic [VA_W-1:0]   lkp_va,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_multi,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [ATTR_W-1:0] rsp_attr,
    input  logic              ref_we,
    input  logic [VPN_W-1:0]  ref_vpn,
    input  logic [ASID_W-1:0] ref_asid,
    input  logic [PPN_W-1:0]  ref_ppn,
    input  logic              ref_shared,
    input  logic [ATTR_W-1:0] ref_attr,
    input  logic              flt_valid,
    input  logic [WAY_W-1:0]  flt_way,
    input  logic [VA_W-1:0]   flt_va
);
    lk_state_t         state_q, state_d;
    logic              xlate_en_q, hash_q, single_q;
    logic [ASID_W-1:0] asid_q;
    logic [VA_W-1:0]   fault_q;
    logic [VA_W-1:0]   req_va_q;
    logic [ASID_W-1:0] req_asid_q;
    logic              accept, in_compare;

    logic [IDX_W-1:0]  lk_idx, rf_idx;
    logic [N_WAYS-1:0] valid_vec, hit_vec;
    logic [PPN_W-1:0]  way_ppn  [N_WAYS];
    logic [ATTR_W-1:0] way_attr [N_WAYS];
    logic [PPN_W-1:0]  hit_ppn;
    logic [ATTR_W-1:0] hit_attr;
    logic              any_hit, multi_hit, miss_evt, multi_evt;
    logic [WAY_W-1:0]  victim_way;
    logic              ctrl_wr, flush_cmd;
    tlb_entry_t        wr_entry;

    logic unused_wdata;
    assign unused_wdata = ^reg_wdata[REG_W-1:B_VICT+WAY_W];

    // ---------------- sequencer: state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- sequencer: next state and outputs ----------------
    always_comb begin
        state_d    = state_q;
        lkp_ready  = 1'b0;
        accept     = 1'b0;
        in_compare = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                lkp_ready = 1'b1;
                accept    = lkp_req;
                if (lkp_req) state_d = ST_COMPARE;   // accept
            end
            ST_COMPARE: begin
                in_compare = 1'b1;
                state_d    = ST_IDLE;                // respond
            end
        endcase
    end

    // ---------------- request capture ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_va_q   <= '0;
            req_asid_q <= '0;
        end else if (accept) begin
            req_va_q   <= lkp_va;
            req_asid_q <= asid_q;
        end
    end

    // ---------------- index generation ----------------
    tlb4_index u_lk_index (
        .vpn     (req_va_q[VA_W-1:PG_W]),
        .asid    (req_asid_q),
        .hash_en (hash_q),
        .idx     (lk_idx)
    );

    tlb4_index u_rf_index (
        .vpn     (ref_vpn),
        .asid    (ref_asid),
        .hash_en (hash_q),
        .idx     (rf_idx)
    );

    // ---------------- way storage ----------------
    assign ctrl_wr   = reg_we && (reg_addr == RA_CTRL);
    assign flush_cmd = ctrl_wr && reg_wdata[B_FLUSH];

    always_comb begin
        wr_entry.vpn    = ref_vpn;
        wr_entry.asid   = ref_asid;
        wr_entry.ppn    = ref_ppn;
        wr_entry.shared = ref_shared;
        wr_entry.attr   = ref_attr;
    end

    for (genvar g = 0; g < N_WAYS; g++) begin : g_way
        tlb4_way u_way (
            .clk          (clk),
            .rst_n        (rst_n),
            .flush        (flush_cmd),
            .wr_en        (ref_we && (victim_way == WAY_W'(g))),
            .wr_idx       (rf_idx),
            .wr_data      (wr_entry),
            .rd_idx       (lk_idx),
            .cmp_vpn      (req_va_q[VA_W-1:PG_W]),
            .cmp_asid     (req_asid_q),
            .single_space (single_q),
            .rd_valid     (valid_vec[g]),
            .rd_match     (hit_vec[g]),
            .rd_ppn       (way_ppn[g]),
            .rd_attr      (way_attr[g])
        );
    end

    always_comb begin
        hit_ppn  = '0;
        hit_attr = '0;
        for (int w = N_WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                hit_ppn  = way_ppn[w];
                hit_attr = way_attr[w];
            end
        end
    end

    assign any_hit   = |hit_vec;
    assign multi_hit = (hit_vec & (hit_vec - 1'b1)) != '0;
    assign miss_evt  = in_compare && xlate_en_q && !any_hit;
    assign multi_evt = in_compare && xlate_en_q && multi_hit;

    // ---------------- victim counter ----------------
    tlb4_victim u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .miss_evt  (miss_evt),
        .multi_evt (multi_evt),
        .valid_vec (valid_vec),
        .hit_vec   (hit_vec),
        .flt_evt   (flt_valid),
        .flt_way   (flt_way),
        .sw_we     (ctrl_wr),
        .sw_way    (reg_wdata[B_VICT +: WAY_W]),
        .way_q     (victim_way)
    );

    // ---------------- response register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_multi <= 1'b0;
            rsp_pa    <= '0;
            rsp_attr  <= '0;
        end else begin
            rsp_valid <= in_compare;
            if (in_compare) begin
                if (!xlate_en_q) begin
                    rsp_hit   <= 1'b1;
                    rsp_miss  <= 1'b0;
                    rsp_multi <= 1'b0;
                    rsp_pa    <= PA_W'(req_va_q);
                    rsp_attr  <= '0;
                end else if (multi_hit) begin
                    rsp_hit   <= 1'b0;
                    rsp_miss  <= 1'b0;
                    rsp_multi <= 1'b1;
                    rsp_pa    <= '0;
                    rsp_attr  <= '0;
                end else if (any_hit) begin
                    rsp_hit   <= 1'b1;
                    rsp_miss  <= 1'b0;
                    rsp_multi <= 1'b0;
                    rsp_pa    <= {hit_ppn, req_va_q[PG_W-1:0]};
                    rsp_attr  <= hit_attr;
                end else begin
                    rsp_hit   <= 1'b0;
                    rsp_miss  <= 1'b1;
                    rsp_multi <= 1'b0;
                    rsp_pa    <= '0;
                    rsp_attr  <= '0;
                end
            end
        end
    end

    // ---------------- control, identifier and fault registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xlate_en_q <= 1'b0;
            hash_q     <= 1'b0;
            single_q   <= 1'b0;
            asid_q     <= '0;
        end else if (reg_we) begin
            if (reg_addr == RA_CTRL) begin
                xlate_en_q <= reg_wdata[B_EN];
                hash_q     <= reg_wdata[B_HASH];
                single_q   <= reg_wdata[B_SINGLE];
            end
            if (reg_addr == RA_ASID) asid_q <= reg_wdata[ASID_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      fault_q <= '0;
        else if (miss_evt || multi_evt)  fault_q <= req_va_q;
        else if (flt_valid)              fault_q <= flt_va;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CTRL: begin
                reg_rdata[B_EN]             = xlate_en_q;
                reg_rdata[B_HASH]           = hash_q;
                reg_rdata[B_SINGLE]         = single_q;
                reg_rdata[B_VICT +: WAY_W]  = victim_way;
            end
            RA_ASID:  reg_rdata[ASID_W-1:0] = asid_q;
            RA_FAULT: reg_rdata[VA_W-1:0]   = fault_q;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tlb4_checker.sv
module tlb4_checker
    import tlb4_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input lk_state_t         state_q,
    input logic              xlate_en_q,
    input logic [VA_W-1:0]   req_va_q,
    input logic [N_WAYS-1:0] valid_vec,
    input logic [N_WAYS-1:0] hit_vec,
    input logic [WAY_W-1:0]  victim_way,
    input logic [VA_W-1:0]   fault_q,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_miss,
    input logic              rsp_multi,
    input logic [PA_W-1:0]   rsp_pa,
    input logic              flt_valid,
    input logic [WAY_W-1:0]  flt_way,
    input logic [VA_W-1:0]   flt_va,
    input logic [1:0]        reg_addr,
    input logic [REG_W-1:0]  reg_rdata
);
    localparam logic [N_WAYS-1:0] WAY_ONE = N_WAYS'(1);

    p_rsp_after_compare_r13: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_COMPARE |=> rsp_valid);

    p_rsp_only_from_compare_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(state_q) == ST_COMPARE);

    p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_multi}) == 1);

    p_bypass_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMPARE && !xlate_en_q)
        |=> rsp_hit && (rsp_pa == PA_W'($past(req_va_q))) && $stable(victim_way) && $stable(fault_q));

    p_miss_captures_va_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMPARE && xlate_en_q && hit_vec == '0) |=> fault_q == $past(req_va_q));

    p_full_set_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMPARE && xlate_en_q && hit_vec == '0 && valid_vec == '1)
        |=> victim_way == WAY_W'($past(victim_way) + 1'b1));

    p_lowest_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMPARE && xlate_en_q && hit_vec == '0 && valid_vec != '1)
        |=> ((($past(valid_vec) >> victim_way) & WAY_ONE) == '0) &&
            (($past(valid_vec) & ((WAY_ONE << victim_way) - WAY_ONE)) == ((WAY_ONE << victim_way) - WAY_ONE)));

    p_multi_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMPARE && xlate_en_q && $countones(hit_vec) > 1)
        |=> rsp_multi && !rsp_hit && (fault_q == $past(req_va_q)) &&
            ((($past(hit_vec) >> victim_way) & WAY_ONE) != '0));

    p_ext_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && !(state_q == ST_COMPARE && xlate_en_q && $countones(hit_vec) != 1))
        |=> (fault_q == $past(flt_va)) && (victim_way == $past(flt_way)));

    p_fault_holds_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!flt_valid && !(state_q == ST_COMPARE && xlate_en_q)) |=> $stable(fault_q));

    p_flush_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == RA_CTRL |-> reg_rdata[B_FLUSH] == 1'b0);

    p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == RA_CTRL |-> (reg_rdata[REG_W-1:B_VICT+WAY_W] == '0) &&
                                (reg_rdata[B_VICT-1:B_SINGLE+1] == '0));
endmodule

bind tlb4_top tlb4_checker u_tlb4_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .xlate_en_q (xlate_en_q),
    .req_va_q   (req_va_q),
    .valid_vec  (valid_vec),
    .hit_vec    (hit_vec),
    .victim_way (victim_way),
    .fault_q    (fault_q),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_miss   (rsp_miss),
    .rsp_multi  (rsp_multi),
    .rsp_pa     (rsp_pa),
    .flt_valid  (flt_valid),
    .flt_way    (flt_way),
    .flt_va     (flt_va),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata)
);

// File: tb/test_tlb4_top.sv
module test_tlb4_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lkp_req = 1'b0;
    logic        lkp_ready;
    logic [31:0] lkp_va = '0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_multi;
    logic [31:0] rsp_pa;
    logic [3:0]  rsp_attr;
    logic        ref_we = 1'b0;
    logic [19:0] ref_vpn = '0;
    logic [7:0]  ref_asid = '0;
    logic [19:0] ref_ppn = '0;
    logic        ref_shared = 1'b0;
    logic [3:0]  ref_attr = '0;
    logic        flt_valid = 1'b0;
    logic [1:0]  flt_way = '0;
    logic [31:0] flt_va = '0;

    always #2 clk = ~clk;

    tlb4_top i_tlb4_top (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lkp_req(lkp_req),
        .lkp_ready(lkp_ready), .lkp_va(lkp_va), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_multi(rsp_multi),
        .rsp_pa(rsp_pa), .rsp_attr(rsp_attr), .ref_we(ref_we), .ref_vpn(ref_vpn),
        .ref_asid(ref_asid), .ref_ppn(ref_ppn), .ref_shared(ref_shared),
        .ref_attr(ref_attr), .flt_valid(flt_valid), .flt_way(flt_way), .flt_va(flt_va)
    );

    int n_chk = 0;
    int n_bad = 0;

    // reference model, built from the requirements
    logic        m_v    [4][32];
    logic [19:0] m_vpn  [4][32];
    logic [7:0]  m_asid [4][32];
    logic [19:0] m_ppn  [4][32];
    logic        m_sh   [4][32];
    logic [3:0]  m_attr [4][32];
    logic [1:0]  m_ctr = '0;
    logic        m_en = 1'b0, m_hash = 1'b0, m_single = 1'b0;
    logic [7:0]  m_cur = '0;
    logic [31:0] m_fault = '0;

    typedef struct packed {
        logic        hit;
        logic        miss;
        logic        multi;
        logic [31:0] pa;
        logic [3:0]  attr;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int m_index(input logic [19:0] vpn, input logic [7:0] asid);
        return m_hash ? int'(vpn[4:0] ^ asid[4:0]) : int'(vpn[4:0]);
    endfunction

    function automatic logic [31:0] ctrl_word(input logic en, input logic hash,
                                              input logic single, input logic [1:0] ctr);
        return {22'b0, ctr, 4'b0, single, 1'b0, hash, en};
    endfunction

    task automatic reg_wr(input logic [1:0] addr, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = addr; reg_wdata = data;
        if (addr == 2'd0) begin
            m_en = data[0]; m_hash = data[1]; m_single = data[3]; m_ctr = data[9:8];
            if (data[2]) for (int w = 0; w < 4; w++) for (int s = 0; s < 32; s++) m_v[w][s] = 1'b0;
        end
        if (addr == 2'd1) m_cur = data[7:0];
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] addr, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = addr;
        #1;
        chk(tag, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic check_ctrl(input string tag);
        reg_rd(2'd0, ctrl_word(m_en, m_hash, m_single, m_ctr), tag);
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [7:0] asid, input logic [19:0] ppn,
                          input logic sh, input logic [3:0] attr);
        int idx;
        @(negedge clk);
        ref_we = 1'b1; ref_vpn = vpn; ref_asid = asid; ref_ppn = ppn; ref_shared = sh; ref_attr = attr;
        idx = m_index(vpn, asid);
        m_v[m_ctr][idx] = 1'b1; m_vpn[m_ctr][idx] = vpn; m_asid[m_ctr][idx] = asid;
        m_ppn[m_ctr][idx] = ppn; m_sh[m_ctr][idx] = sh; m_attr[m_ctr][idx] = attr;
        @(negedge clk);
        ref_we = 1'b0;
    endtask

    // driver: computes the expected response, queues it, and drives the request
    task automatic lookup_f(input logic [31:0] va, input string tag, input logic with_flt,
                            input logic [1:0] fw, input logic [31:0] fv);
        exp_t e;
        int idx, nm, first;
        logic [19:0] vpn;
        logic allv;
        vpn = va[31:12];
        idx = m_index(vpn, m_cur);
        e = '0; nm = 0; first = -1; allv = 1'b1;
        for (int w = 0; w < 4; w++) begin
            if (!m_v[w][idx]) allv = 1'b0;
            if (m_v[w][idx] && m_vpn[w][idx] == vpn &&
                (m_single || m_sh[w][idx] || m_asid[w][idx] == m_cur)) begin
                nm++;
                if (first < 0) first = w;
            end
        end
        if (!m_en) begin
            e.hit = 1'b1; e.pa = va;
        end else if (nm == 1) begin
            e.hit = 1'b1; e.pa = {m_ppn[first][idx], va[11:0]}; e.attr = m_attr[first][idx];
        end else if (nm > 1) begin
            e.multi = 1'b1; m_ctr = 2'(first); m_fault = va;
        end else begin
            e.miss = 1'b1; m_fault = va;
            if (allv) m_ctr = m_ctr + 2'd1;
            else begin
                for (int w = 3; w >= 0; w--) if (!m_v[w][idx]) m_ctr = 2'(w);
            end
        end
        if (with_flt && !(m_en && nm != 1)) begin
            m_ctr = fw; m_fault = fv;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        chk({tag, " ready idle"}, 64'(lkp_ready), 64'd1);
        lkp_req = 1'b1; lkp_va = va;
        @(negedge clk);
        lkp_req = 1'b0;
        chk("R13 ready low in compare", 64'(lkp_ready), 64'd0);
        if (with_flt) begin
            flt_valid = 1'b1; flt_way = fw; flt_va = fv;
        end
        @(negedge clk);
        flt_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic lookup(input logic [31:0] va, input string tag);
        lookup_f(va, tag, 1'b0, 2'd0, 32'd0);
    endtask

    // monitor: pops the expected response when the design produces one
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk("R13 unexpected response", 64'(rsp_valid), 64'd0);
            end else begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, 64'({rsp_hit, rsp_miss, rsp_multi, rsp_pa, rsp_attr}), 64'(e));
            end
        end
    end

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R13 watchdog actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        for (int w = 0; w < 4; w++) for (int s = 0; s < 32; s++) begin
            m_v[w][s] = 1'b0; m_vpn[w][s] = '0; m_asid[w][s] = '0;
            m_ppn[w][s] = '0; m_sh[w][s] = 1'b0; m_attr[w][s] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R11: reset values and empty address
        reg_rd(2'd0, 32'd0, "R1 ctrl after reset");
        reg_rd(2'd1, 32'd0, "R1 asid after reset");
        reg_rd(2'd2, 32'd0, "R1 fault after reset");
        reg_rd(2'd3, 32'd0, "R11 address 3 reads zero");

        // R12: translation off passes the address through
        lookup(32'h1234_5678, "R12 bypass");
        check_ctrl("R12 counter untouched");
        reg_rd(2'd2, 32'd0, "R12 fault untouched");

        // R1 / R4 / R6: enable, first lookup misses into way 0
        reg_wr(2'd0, ctrl_word(1'b1, 1'b0, 1'b0, m_ctr));
        lookup(32'h0000_3ABC, "R1 first enabled lookup misses");
        reg_rd(2'd2, m_fault, "R4 fault captures VA");
        check_ctrl("R6 lowest free way 0");

        // R9 / R3: refill and hit
        refill(20'h00003, 8'h00, 20'hABCDE, 1'b0, 4'h5);
        lookup(32'h0000_3123, "R3 R9 hit after refill");

        // R6: fill set 3 way by way
        lookup(32'h0002_3000, "R4 miss same set");
        check_ctrl("R6 lowest free way 1");
        refill(20'h00023, 8'h00, 20'h11111, 1'b0, 4'h1);
        lookup(32'h0004_3000, "R4 miss same set");
        check_ctrl("R6 lowest free way 2");
        refill(20'h00043, 8'h00, 20'h22222, 1'b0, 4'h2);
        lookup(32'h0006_3000, "R4 miss same set");
        check_ctrl("R6 lowest free way 3");
        refill(20'h00063, 8'h00, 20'h33333, 1'b0, 4'h3);
        lookup(32'h0004_3FFF, "R3 hit way 2");

        // R5: full set advances the counter with wrap
        lookup(32'h0008_3000, "R5 miss on full set");
        check_ctrl("R5 counter wraps 3 to 0");
        lookup(32'h000A_3000, "R5 miss on full set");
        check_ctrl("R5 counter 0 to 1");

        // R3: identifier rules
        reg_wr(2'd1, 32'h0000_0011);
        lookup(32'h0000_3123, "R3 identifier mismatch misses");
        refill(20'h00105, 8'h11, 20'h55555, 1'b1, 4'hA);
        reg_wr(2'd1, 32'h0000_0022);
        lookup(32'h0010_5010, "R3 shared entry hits any identifier");
        reg_wr(2'd0, ctrl_word(1'b1, 1'b0, 1'b1, m_ctr));
        lookup(32'h0000_3456, "R3 single space ignores identifier");

        // R2: hashed index
        reg_wr(2'd0, ctrl_word(1'b1, 1'b1, 1'b0, m_ctr));
        reg_wr(2'd1, 32'h0000_0005);
        refill(20'h00200, 8'h05, 20'h77777, 1'b0, 4'h7);
        lookup(32'h0020_0ABC, "R2 hashed index hit");
        reg_wr(2'd0, ctrl_word(1'b1, 1'b0, 1'b0, m_ctr));
        lookup(32'h0020_0ABC, "R2 plain index misses");

        // R7: multiple hit, built by steering the counter
        reg_wr(2'd1, 32'h0000_0000);
        reg_wr(2'd0, ctrl_word(1'b1, 1'b0, 1'b0, 2'd3));
        refill(20'h00310, 8'h00, 20'h0AAAA, 1'b0, 4'h1);
        reg_wr(2'd0, ctrl_word(1'b1, 1'b0, 1'b0, 2'd1));
        refill(20'h00310, 8'h00, 20'h0BBBB, 1'b0, 4'h2);
        reg_wr(2'd0, ctrl_word(1'b1, 1'b0, 1'b0, 2'd2));
        lookup(32'h0031_0444, "R7 multiple hit");
        check_ctrl("R7 counter lowest matching way");
        reg_rd(2'd2, m_fault, "R7 fault captures VA");

        // R8: external fault, and its lower priority
        @(negedge clk);
        flt_valid = 1'b1; flt_way = 2'd2; flt_va = 32'hDEAD_0000;
        m_ctr = 2'd2; m_fault = 32'hDEAD_0000;
        @(negedge clk);
        flt_valid = 1'b0;
        check_ctrl("R8 counter from fault way");
        reg_rd(2'd2, m_fault, "R8 fault address");
        lookup_f(32'h0055_5000, "R8 miss with fault same cycle", 1'b1, 2'd3, 32'hBEEF_0000);
        check_ctrl("R8 miss wins counter");
        reg_rd(2'd2, m_fault, "R8 miss wins fault address");
        lookup_f(32'h0000_3123, "R8 hit with fault same cycle", 1'b1, 2'd1, 32'hCAFE_0000);
        reg_rd(2'd2, m_fault, "R8 fault applies on plain hit");

        // R11: fault register ignores writes
        reg_wr(2'd2, 32'hFFFF_FFFF);
        reg_rd(2'd2, m_fault, "R11 fault write ignored");

        // R10: flush wins over a same-cycle refill
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = ctrl_word(1'b1, 1'b0, 1'b0, 2'd2) | 32'h4;
        ref_we = 1'b1; ref_vpn = 20'h00400; ref_asid = 8'h00; ref_ppn = 20'h99999;
        ref_shared = 1'b0; ref_attr = 4'hF;
        m_ctr = 2'd2;
        for (int w = 0; w < 4; w++) for (int s = 0; s < 32; s++) m_v[w][s] = 1'b0;
        @(negedge clk);
        reg_we = 1'b0; ref_we = 1'b0;
        check_ctrl("R10 flush bit reads zero");
        lookup(32'h0000_3123, "R10 flushed entry misses");
        lookup(32'h0040_0000, "R10 same-cycle refill discarded");
        check_ctrl("R6 after flush counter way 0");

        repeat (4) @(negedge clk);
        chk("R13 all responses seen", 64'(exp_q.size()), 64'd0);
        report();
        $finish;
    end
endmodule